// File: doc/BRIEF.md
# Two-Step Register Write Unlock Guard

This block sits behind a byte-oriented serial bus target and controls whether writes to a range of protected clock and control registers may go ahead. It watches decoded write transactions. Each transaction is bounded by a bus start and a bus stop event. The block keeps two volatile latches: a write-enable latch and a register-write-enable latch. Both are cleared at reset. A protected write is allowed only after two unlock transactions have been completed in order, each containing exactly one write to the status register. The first must carry the byte 02h. The second must carry the byte 06h. Every other bit of these bytes must be zero.

Two state machines do the work. The frame tracker has the states FR_IDLE, FR_OPEN, FR_HELD and FR_VOID. Its transitions are:
- start opens a frame.
- The first status write holds its byte (FR_OPEN to FR_HELD).
- A second status write spoils the frame (FR_HELD to FR_VOID).
- A repeated start discards whatever the frame held (back to FR_OPEN).
- A stop closes the frame (to FR_IDLE). A stop in FR_HELD also commits the held byte.

The latch machine has the states LK_LOCKED, LK_WEL and LK_OPEN. It moves only on a commit:
- 00h goes to LK_LOCKED from any state.
- 02h goes to LK_WEL from any state.
- 06h moves LK_WEL to LK_OPEN and leaves LK_LOCKED unchanged.
- Any other byte changes nothing.

The write permit is combinational. It is raised for a write strobe inside an open frame that targets the protected range while the latch machine is in LK_OPEN. Protected writes without the permit are meant to be dropped by the register storage.

Top module: `reg_unlock_guard`

## Requirements
- R1: After reset, wel_o and rwel_o are 0, and wr_permit_o is 0 for every input pattern until the unlock sequence completes.
- R2: A committed status byte of exactly 02h leaves wel_o=1 and rwel_o=0, whatever the previous latch state (so from the unlocked state it drops rwel_o).
- R3: A committed status byte of exactly 06h while wel_o=1 sets both wel_o and rwel_o to 1.
- R4: A committed 06h while wel_o=0 has no effect: both latches stay 0.
- R5: A committed status byte other than 00h, 02h or 06h (for example 82h, 07h or 04h) leaves both latches unchanged.
- R6: A committed status byte of exactly 00h clears both latches.
- R7: A status byte is committed only at a stop that closes a frame holding exactly one status write. The latch outputs change on the clock edge that ends the stop cycle and are unchanged before it. A repeated start inside a frame discards the held byte.
- R8: A frame with two or more status writes commits nothing, so the latches stay unchanged.
- R9: A write strobe outside a frame (before any start, or after a stop) is ignored. It neither stages a status byte nor raises wr_permit_o.
- R10: wr_permit_o is 1 exactly when wr_strobe is 1 inside an open frame, bus_start and bus_stop are 0, wr_addr lies in PROT_LO..PROT_HI, and both latches are 1. Otherwise it is 0, including for the status address and for addresses outside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears both latches |
| bus_start | input | 1 | One-cycle pulse: bus start (or repeated start) seen |
| bus_stop | input | 1 | One-cycle pulse: bus stop seen |
| wr_strobe | input | 1 | One-cycle pulse: a decoded data byte is being written |
| wr_addr | input | ADDR_W | Register address of the decoded write |
| wr_data | input | 8 | Data byte of the decoded write |
| wel_o | output | 1 | Write-enable latch state |
| rwel_o | output | 1 | Register-write-enable latch state |
| wr_permit_o | output | 1 | Current write may update a protected register |

## Verification
The assertions assume that bus_start, bus_stop and wr_strobe each arrive as single-cycle events coming from an upstream bit engine. They also assume that these three are never asserted together in one cycle, apart from the start-and-stop overlap that the frame tracker resolves in favour of the stop. The bench drives its stimulus through a single task that raises at most one of the three in any cycle and returns the inputs to idle between transactions. This keeps every property within the input protocol it relies on. The reference model then follows the same framing rules at the level of behaviour: it holds an integer staged byte, an in-frame flag and two latch flags.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] BYTE_RELOCK = 8'h00;
    localparam logic [DATA_W-1:0] BYTE_STEP1  = 8'h02;
    localparam logic [DATA_W-1:0] BYTE_STEP2  = 8'h06;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_OPEN = 2'd1,
        FR_HELD = 2'd2,
        FR_VOID = 2'd3
    } frame_st_t;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_WEL    = 2'd1,
        LK_OPEN   = 2'd2
    } lock_st_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_STEP1 = 2'd2,
        CMD_STEP2 = 2'd3
    } unlock_cmd_t;

    // Whole-byte compare: any stray set bit makes the byte a no-op.
    function automatic unlock_cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        unlock_cmd_t c;
        c = CMD_NONE;
        if (b == BYTE_RELOCK)     c = CMD_CLEAR;
        else if (b == BYTE_STEP1) c = CMD_STEP1;
        else if (b == BYTE_STEP2) c = CMD_STEP2;
        return c;
    endfunction

endpackage

// File: rtl/unlock_addr_decode.sv
module unlock_addr_decode
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h3F,
    parameter logic [ADDR_W-1:0] PROT_LO = 8'h10,
    parameter logic [ADDR_W-1:0] PROT_HI = 8'h14
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              status_hit_o,
    output logic              prot_hit_o
);

    localparam bit SINGLE_PROT = (PROT_LO == PROT_HI);

    always_comb begin
        status_hit_o = (addr_i == STATUS_ADDR);
    end

    generate
        if (SINGLE_PROT) begin : g_single
            always_comb begin
                prot_hit_o = (addr_i == PROT_LO);
            end
        end else begin : g_range
            always_comb begin
                prot_hit_o = (addr_i >= PROT_LO) && (addr_i <= PROT_HI);
            end
        end
    endgenerate

    // The status register must never be inside the guarded range.
    initial begin
        status_outside_range_chk: assert (!((STATUS_ADDR >= PROT_LO) && (STATUS_ADDR <= PROT_HI)))
            else $error("status address lies inside the protected range");
    end

endmodule

// File: rtl/unlock_frame_tracker.sv
module unlock_frame_tracker
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start_i,
    input  logic              bus_stop_i,
    input  logic              wr_strobe_i,
    input  logic              status_hit_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              in_frame_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] held_byte_o
);

    frame_st_t         st_q, st_d;
    logic [DATA_W-1:0] held_q;
    logic              status_wr;
    logic              capture;

    always_comb begin
        status_wr = wr_strobe_i && status_hit_i && !bus_start_i && !bus_stop_i;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE: begin
                if (bus_start_i && !bus_stop_i) st_d = FR_OPEN;
            end
            FR_OPEN: begin
                if (bus_stop_i)       st_d = FR_IDLE;
                else if (bus_start_i) st_d = FR_OPEN;
                else if (status_wr)   st_d = FR_HELD;
            end
            FR_HELD: begin
                if (bus_stop_i)       st_d = FR_IDLE;
                else if (bus_start_i) st_d = FR_OPEN;
                else if (status_wr)   st_d = FR_VOID;
            end
            FR_VOID: begin
                if (bus_stop_i)       st_d = FR_IDLE;
                else if (bus_start_i) st_d = FR_OPEN;
            end
            default: st_d = FR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Staged status byte
    always_comb begin
        capture = (st_q == FR_OPEN) && status_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (capture) begin
            held_q <= wr_data_i;
        end
    end

    // Outputs
    always_comb begin
        in_frame_o  = (st_q != FR_IDLE);
        commit_o    = (st_q == FR_HELD) && bus_stop_i;
        held_byte_o = held_q;
    end

    // R7
    commit_closes_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (st_q == FR_IDLE));

    // R9
    idle_no_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_IDLE && !bus_start_i) |=> (st_q == FR_IDLE));

    // R8
    void_stays_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_VOID && !bus_start_i && !bus_stop_i) |=> (st_q == FR_VOID));

endmodule

// File: rtl/unlock_latch_fsm.sv
module unlock_latch_fsm
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              wel_o,
    output logic              rwel_o,
    output logic              open_o
);

    lock_st_t    lk_q, lk_d;
    unlock_cmd_t cmd;

    always_comb begin
        cmd = commit_i ? decode_cmd(byte_i) : CMD_NONE;
    end

    // Next-state logic
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_LOCKED: begin
                if (cmd == CMD_STEP1) lk_d = LK_WEL;
            end
            LK_WEL: begin
                if (cmd == CMD_CLEAR)      lk_d = LK_LOCKED;
                else if (cmd == CMD_STEP2) lk_d = LK_OPEN;
            end
            LK_OPEN: begin
                if (cmd == CMD_CLEAR)      lk_d = LK_LOCKED;
                else if (cmd == CMD_STEP1) lk_d = LK_WEL;
            end
            default: lk_d = LK_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_LOCKED;
        end else begin
            lk_q <= lk_d;
        end
    end

    // Outputs
    always_comb begin
        wel_o  = (lk_q == LK_WEL) || (lk_q == LK_OPEN);
        rwel_o = (lk_q == LK_OPEN);
        open_o = (lk_q == LK_OPEN);
    end

    // R4
    no_skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_LOCKED) |=> (lk_q != LK_OPEN));

    // R6
    relock_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && byte_i == BYTE_RELOCK) |=> (lk_q == LK_LOCKED));

    // R3
    second_step_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_WEL && commit_i && byte_i == BYTE_STEP2) |=> (lk_q == LK_OPEN));

    // R5
    odd_byte_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i || (byte_i != BYTE_RELOCK && byte_i != BYTE_STEP1 && byte_i != BYTE_STEP2))
        |=> $stable(lk_q));

    // R2
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && byte_i == BYTE_STEP1) |=> (lk_q == LK_WEL));

endmodule

// File: rtl/reg_unlock_guard.sv
module reg_unlock_guard
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h3F,
    parameter logic [ADDR_W-1:0] PROT_LO = 8'h10,
    parameter logic [ADDR_W-1:0] PROT_HI = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wel_o,
    output logic              rwel_o,
    output logic              wr_permit_o
);

    logic              status_hit;
    logic              prot_hit;
    logic              in_frame;
    logic              commit;
    logic [DATA_W-1:0] held_byte;
    logic              unlocked;

    unlock_addr_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .PROT_LO     (PROT_LO),
        .PROT_HI     (PROT_HI)
    ) u_decode (
        .addr_i       (wr_addr),
        .status_hit_o (status_hit),
        .prot_hit_o   (prot_hit)
    );

    unlock_frame_tracker u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_start_i  (bus_start),
        .bus_stop_i   (bus_stop),
        .wr_strobe_i  (wr_strobe),
        .status_hit_i (status_hit),
        .wr_data_i    (wr_data),
        .in_frame_o   (in_frame),
        .commit_o     (commit),
        .held_byte_o  (held_byte)
    );

    unlock_latch_fsm u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .byte_i   (held_byte),
        .wel_o    (wel_o),
        .rwel_o   (rwel_o),
        .open_o   (unlocked)
    );

    always_comb begin
        wr_permit_o = wr_strobe && in_frame && !bus_start && !bus_stop
                      && prot_hit && unlocked;
    end

    // R10
    permit_needs_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit_o |-> (wel_o && rwel_o));

    // R10
    permit_only_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit_o |-> (wr_addr >= PROT_LO && wr_addr <= PROT_HI));

    // R1
    rwel_implies_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_o |-> wel_o);

endmodule

// File: tb/reg_unlock_guard_tb.sv
module reg_unlock_guard_tb_top;

    localparam int ST_ADDR = 8'h3F;
    localparam int P_LO    = 8'h10;
    localparam int P_HI    = 8'h14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       wel_o, rwel_o, wr_permit_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_wel = 0;
    int m_rwel = 0;
    int m_inframe = 0;
    int m_pend = -1;   // -1 none, -2 spoiled, else byte

    always #5 clk = ~clk;

    reg_unlock_guard dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_start (bus_start), .bus_stop (bus_stop),
        .wr_strobe (wr_strobe), .wr_addr (wr_addr), .wr_data (wr_data),
        .wel_o (wel_o), .rwel_o (rwel_o), .wr_permit_o (wr_permit_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_apply(input int b);
        if (b == 0) begin m_wel = 0; m_rwel = 0; end
        else if (b == 2) begin m_wel = 1; m_rwel = 0; end
        else if (b == 6) begin if (m_wel == 1) m_rwel = 1; end
    endtask

    // One clock of stimulus: drive at negedge, check permit mid-cycle,
    // advance model at the edge, check latches after it.
    task automatic step(input bit s, input bit p, input bit w, input int a, input int d,
                        input string req);
        int exp_permit;
        bus_start = s; bus_stop = p; wr_strobe = w;
        wr_addr = a[7:0]; wr_data = d[7:0];
        #2;
        exp_permit = (w && !s && !p && m_inframe == 1 && a >= P_LO && a <= P_HI
                      && m_wel == 1 && m_rwel == 1) ? 1 : 0;
        chk(req, "wr_permit_o", int'(wr_permit_o), exp_permit);
        @(posedge clk);
        if (p) begin
            if (m_inframe == 1 && m_pend >= 0) model_apply(m_pend);
            m_inframe = 0; m_pend = -1;
        end else if (s) begin
            m_inframe = 1; m_pend = -1;
        end else if (w && m_inframe == 1 && a == ST_ADDR) begin
            m_pend = (m_pend == -1) ? d : -2;
        end
        @(negedge clk);
        chk(req, "wel_o", int'(wel_o), m_wel);
        chk(req, "rwel_o", int'(rwel_o), m_rwel);
        bus_start = 0; bus_stop = 0; wr_strobe = 0;
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, req);
    endtask

    task automatic frame_write(input int a, input int d, input string req);
        step(1, 0, 0, 0, 0, req);
        step(0, 0, 1, a, d, req);
        step(0, 1, 0, 0, 0, req);
        idle(req);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wel after reset", int'(wel_o), 0);
        chk("R1", "rwel after reset", int'(rwel_o), 0);
        idle("R1");

        // R9 protected and status writes outside any frame
        step(0, 0, 1, P_LO, 8'h55, "R9");
        step(0, 0, 1, ST_ADDR, 8'h02, "R9");
        step(0, 1, 0, 0, 0, "R9");
        chk("R9", "wel after stray write", int'(wel_o), 0);

        // R1 protected write in a frame while locked
        step(1, 0, 0, 0, 0, "R1");
        step(0, 0, 1, P_LO + 1, 8'hAA, "R1");
        step(0, 1, 0, 0, 0, "R1");

        // R4 second byte without the first
        frame_write(ST_ADDR, 8'h06, "R4");
        chk("R4", "rwel after lone 06h", int'(rwel_o), 0);

        // R7 nothing changes before the stop
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, ST_ADDR, 8'h02, "R7");
        idle("R7");
        chk("R7", "wel before stop", int'(wel_o), 0);
        step(0, 1, 0, 0, 0, "R7");
        chk("R7", "wel right after stop", int'(wel_o), 1);
        idle("R2");

        // R5 stray bits / other values
        frame_write(ST_ADDR, 8'h86, "R5");
        frame_write(ST_ADDR, 8'h04, "R5");
        chk("R5", "rwel after odd byte", int'(rwel_o), 0);
        chk("R5", "wel after odd byte", int'(wel_o), 1);

        // R3 second step
        frame_write(ST_ADDR, 8'h06, "R3");
        chk("R3", "rwel after 06h", int'(rwel_o), 1);

        // R10 permit decode
        step(1, 0, 0, 0, 0, "R10");
        step(0, 0, 1, P_LO, 8'h11, "R10");
        step(0, 0, 1, P_HI, 8'h12, "R10");
        step(0, 0, 1, P_HI + 1, 8'h13, "R10");
        step(0, 0, 1, P_LO - 1, 8'h14, "R10");
        step(0, 0, 0, P_LO, 8'h15, "R10");
        step(0, 1, 0, 0, 0, "R10");
        step(0, 0, 1, P_LO, 8'h16, "R10");
        frame_write(ST_ADDR, 8'h07, "R5");
        chk("R5", "rwel kept after 07h", int'(rwel_o), 1);

        // R2 first step from unlocked drops rwel
        frame_write(ST_ADDR, 8'h02, "R2");
        chk("R2", "rwel after 02h from open", int'(rwel_o), 0);
        chk("R2", "wel after 02h from open", int'(wel_o), 1);
        frame_write(ST_ADDR, 8'h06, "R3");

        // R6 relock
        frame_write(ST_ADDR, 8'h00, "R6");
        chk("R6", "wel after 00h", int'(wel_o), 0);
        chk("R6", "rwel after 00h", int'(rwel_o), 0);

        // R7 repeated start discards held byte
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, ST_ADDR, 8'h02, "R7");
        step(1, 0, 0, 0, 0, "R7");
        step(0, 1, 0, 0, 0, "R7");
        chk("R7", "wel after discarded frame", int'(wel_o), 0);

        // R8 two status writes in one frame
        step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 1, ST_ADDR, 8'h02, "R8");
        step(0, 0, 1, ST_ADDR, 8'h02, "R8");
        step(0, 1, 0, 0, 0, "R8");
        chk("R8", "wel after double write", int'(wel_o), 0);
        frame_write(ST_ADDR, 8'h02, "R2");
        step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 1, ST_ADDR, 8'h06, "R8");
        step(0, 0, 1, ST_ADDR, 8'h00, "R8");
        step(0, 1, 0, 0, 0, "R8");
        chk("R8", "wel kept after spoiled frame", int'(wel_o), 1);
        chk("R8", "rwel kept after spoiled frame", int'(rwel_o), 0);
        idle("R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule